// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Slave

This block is the host-facing slave port of a chip's internal register bank. A processor reaches up to 256 byte addresses through one port. The port accepts two strobe conventions. In separate-strobe mode there is one read strobe and one write strobe. In data-strobe mode there is a single data strobe, and a read/write level picks the direction. The address can arrive on its own lines. It can also share the lines with data and be marked by an address-valid pulse. A static width select chooses either an 8-bit data path or a 16-bit path with byte-lane control.

All host inputs cross into the system clock through a two-flop synchronizer. The decoder turns each access into a read lookup or a single write commit toward a small register file. That file holds 16-bit words stored as two byte lanes. The output stage returns read data and raises the data-bus output enable while a qualified read lasts. Pad cells are not part of this block. The output enable is meant to drive the tri-state buffers outside it.

Top module: `hostbus_regif`

## Requirements
- R1: While `rst` is high, the block samples `mode_ds_i` and `wide_i` and holds them. Changes on these inputs after reset has been released have no effect. During and just after reset, `data_oe_o` is 0 and `data_o` is 0.
- R2: Multiplexed addressing. While `ale_i` is high, the block takes the address from `addr_i`. When `ale_i` falls, the block keeps the last address it saw. Later values on `addr_i` do not change which register the access uses.
- R3: Separate addressing. With `ale_i` held high, the register is selected directly by `addr_i`.
- R4: Separate-strobe read. With `cs_n_i`=0, `rd_n_i`=0 and `wr_n_i`=1, the addressed data appears on `data_o` and `data_oe_o` is 1. Both are valid from the fourth rising clock edge after the strobe is asserted.
- R5: Separate-strobe write. With `cs_n_i`=0 and `wr_n_i`=0, the data on `data_i` is stored. The store happens when the strobe or the chip select is released.
- R6: Data-strobe mode. `rd_n_i` is an active-low data strobe, qualified by `cs_n_i`=0. `wr_n_i` carries the direction: 1 means read and 0 means write.
- R7: 16-bit mode (`wide_i`=1 at reset). The low lane, `data[7:0]`, is enabled when address bit 0 is 0. The high lane, `data[15:8]`, is enabled when `bhe_n_i`=0. Lanes that are not enabled are neither written nor driven, and read as 0.
- R8: 8-bit mode (`wide_i`=0 at reset). Each byte address holds one byte: an even address maps to the low lane of word addr/2, and an odd address maps to the high lane. Write data is taken from `data_i[7:0]`. Read data appears on `data_o[7:0]`, and `data_o[15:8]` reads 0.
- R9: `data_oe_o` is 1 only during a qualified read. It is never 1 unless `cs_n_i` was 0 four clock edges earlier. While `data_oe_o` is 0, `data_o` is 0.
- R10: Byte addresses 32 and above are unmapped. Reads from them return 0. Writes to them change no register; in particular, they do not alias onto words 0 to 15.
- R11: Each write access commits exactly once. Internally, this is a single-cycle write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ds_i | input | 1 | 1 selects data-strobe mode, 0 selects separate strobes (sampled in reset) |
| wide_i | input | 1 | 1 selects 16-bit path, 0 selects 8-bit path (sampled in reset) |
| cs_n_i | input | 1 | Chip select, active low |
| ale_i | input | 1 | Address valid; held high for separate addressing |
| rd_n_i | input | 1 | Read strobe, or data strobe in data-strobe mode, active low |
| wr_n_i | input | 1 | Write strobe, or read/write level in data-strobe mode |
| bhe_n_i | input | 1 | High byte enable, active low (16-bit mode) |
| addr_i | input | 8 | Byte address, or shared address/data lines |
| data_i | input | 16 | Write data from the host |
| data_o | output | 16 | Read data to the host |
| data_oe_o | output | 1 | Data-bus output enable |

## Verification
The bench drives mixed random and directed accesses under every mode and width. Each read is compared with a byte-level model of the register bank.

Faults show up at the ports, usually by the next read:
- A bad address latch returns another register's contents.
- A wrong lane decode corrupts or zeroes one byte of the result.
- A missing or duplicated commit leaves stale data in place.
- A mis-decoded strobe drives the bus during a write or leaves it silent on a read.
- An output-enable fault is visible within four clock edges of the strobe change.

// File: rtl/hb_pkg.sv
package hb_pkg;

  localparam int unsigned LANE_W = 8;

  // Reorders and masks a stored word into what the host sees.
  function automatic logic [15:0] hb_present(input logic [15:0] word,
                                             input logic [1:0]  lanes,
                                             input logic        odd,
                                             input logic        wide);
    logic [15:0] res;
    if (wide) begin
      res[7:0]  = lanes[0] ? word[7:0]  : 8'h00;
      res[15:8] = lanes[1] ? word[15:8] : 8'h00;
    end else begin
      res = {8'h00, (odd ? word[15:8] : word[7:0])};
    end
    return res;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hb_decode.sv
module hb_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 16,
  localparam int unsigned IDX_W = ADDR_W - 1,
  localparam int unsigned LANES = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ds_mode,
  input  logic              wide,
  input  logic              s_cs,
  input  logic              s_stb,
  input  logic              s_wrpin,
  input  logic              s_ale,
  input  logic              s_bhe,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DW-1:0]     s_data,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [LANES-1:0]  rd_lanes,
  output logic              rd_odd,
  output logic              wr_commit,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [LANES-1:0]  wr_be,
  output logic [DW-1:0]     wr_data
);
  logic [ADDR_W-1:0] addr_hold;
  logic [ADDR_W-1:0] eff_addr;
  logic              wr_req;
  logic              wr_seen;
  logic [LANES-1:0]  lanes_now;
  logic [DW-1:0]     data_now;

  // address latch: transparent while ale is high, holds after it falls
  always_ff @(posedge clk) begin
    if (rst) addr_hold <= '0;
    else if (s_ale) addr_hold <= s_addr;
  end

  assign eff_addr = s_ale ? s_addr : addr_hold;

  // strobe decode for both protocols; wrpin is the raw write/rw level
  always_comb begin
    if (ds_mode) begin
      rd_req = s_cs & s_stb & s_wrpin;
      wr_req = s_cs & s_stb & ~s_wrpin;
    end else begin
      rd_req = s_cs & s_stb & s_wrpin;
      wr_req = s_cs & ~s_wrpin;
    end
  end

  assign lanes_now[0] = ~eff_addr[0];
  assign lanes_now[1] = wide ? s_bhe : eff_addr[0];
  assign data_now     = wide ? s_data : {s_data[7:0], s_data[7:0]};

  assign rd_idx   = eff_addr[ADDR_W-1:1];
  assign rd_lanes = lanes_now;
  assign rd_odd   = eff_addr[0];

  // capture while the write strobe is active, commit on its release
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= 1'b0;
      wr_idx  <= '0;
      wr_be   <= '0;
      wr_data <= '0;
    end else begin
      wr_seen <= wr_req;
      if (wr_req) begin
        wr_idx  <= eff_addr[ADDR_W-1:1];
        wr_be   <= lanes_now;
        wr_data <= data_now;
      end
    end
  end

  assign wr_commit = wr_seen & ~wr_req;
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned DW        = 16,
  parameter int unsigned NUM_WORDS = 16,
  localparam int unsigned LANES = DW / 8,
  localparam int unsigned AW    = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LANES-1:0] wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_WORDS);

  logic          wr_hit;
  logic          rd_hit_q;
  logic [DW-1:0] rd_q;

  assign wr_hit = wr_idx < LIMIT;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [NUM_WORDS];
    always_ff @(posedge clk) begin
      if (we && wr_be[g] && wr_hit) mem[wr_idx[AW-1:0]] <= wr_data[g*8 +: 8];
      rd_q[g*8 +: 8] <= mem[rd_idx[AW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_hit_q <= 1'b0;
    else     rd_hit_q <= rd_idx < LIMIT;
  end

  assign rd_data = rd_hit_q ? rd_q : '0;
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned NUM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ds_i,
  input  logic              wide_i,
  input  logic              cs_n_i,
  input  logic              ale_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              bhe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o
);
  import hb_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 1;
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned SW    = 5 + ADDR_W + DW;
  localparam logic [SW-1:0] SYNC_RST = {3'b001, {(2 + ADDR_W + DW){1'b0}}};

  logic              ds_q, wide_q;
  logic [SW-1:0]     raw_in, sync_out;
  logic              s_cs, s_stb, s_wrpin, s_ale, s_bhe;
  logic [ADDR_W-1:0] s_addr;
  logic [DW-1:0]     s_data;
  logic              rd_req, rd_odd, wr_commit;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [LANES-1:0]  rd_lanes, wr_be;
  logic [DW-1:0]     wr_data, rd_data;
  logic              rd_d1, odd_d1;
  logic [LANES-1:0]  lanes_d1;

  // static configuration, captured only while in reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ds_q   <= mode_ds_i;
      wide_q <= wide_i;
    end
  end

  assign raw_in = {~cs_n_i, ~rd_n_i, wr_n_i, ale_i, ~bhe_n_i, addr_i, data_i};

  hb_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  assign {s_cs, s_stb, s_wrpin, s_ale, s_bhe, s_addr, s_data} = sync_out;

  hb_decode #(.ADDR_W(ADDR_W), .DW(DW)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .ds_mode   (ds_q),
    .wide      (wide_q),
    .s_cs      (s_cs),
    .s_stb     (s_stb),
    .s_wrpin   (s_wrpin),
    .s_ale     (s_ale),
    .s_bhe     (s_bhe),
    .s_addr    (s_addr),
    .s_data    (s_data),
    .rd_req    (rd_req),
    .rd_idx    (rd_idx),
    .rd_lanes  (rd_lanes),
    .rd_odd    (rd_odd),
    .wr_commit (wr_commit),
    .wr_idx    (wr_idx),
    .wr_be     (wr_be),
    .wr_data   (wr_data)
  );

  hb_regfile #(.IDX_W(IDX_W), .DW(DW), .NUM_WORDS(NUM_WORDS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_commit),
    .wr_idx  (wr_idx),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // read data stage, aligned with the register-file read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d1     <= 1'b0;
      odd_d1    <= 1'b0;
      lanes_d1  <= '0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      rd_d1     <= rd_req;
      odd_d1    <= rd_odd;
      lanes_d1  <= rd_lanes;
      data_oe_o <= rd_d1;
      data_o    <= rd_d1 ? hb_present(rd_data, lanes_d1, odd_d1, wide_q) : '0;
    end
  end
endmodule

// File: rtl/hostbus_regif_chk.sv
module hostbus_regif_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n_i,
  input logic          data_oe_o,
  input logic [DW-1:0] data_o,
  input logic          wr_commit,
  input logic          ds_q,
  input logic          wide_q
);
  // R9: bus driven only if chip select was active four edges back
  p_oe_needs_cs_r9: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> !$past(cs_n_i, 4));

  // R9: quiet bus when not enabled
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));

  // R11: a commit is a single-cycle pulse
  p_single_commit_r11: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);

  // R1: configuration is frozen outside reset
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $stable(ds_q) && $stable(wide_q));

  // R8: narrow reads never drive the upper byte
  p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!wide_q && data_oe_o) |-> (data_o[DW-1:8] == '0));
endmodule

bind hostbus_regif hostbus_regif_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n_i    (cs_n_i),
  .data_oe_o (data_oe_o),
  .data_o    (data_o),
  .wr_commit (wr_commit),
  .ds_q      (ds_q),
  .wide_q    (wide_q)
);

// File: tb/hostbus_regif_test.sv
`timescale 1ns/1ps
module hostbus_regif_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_ds_i = 1'b0, wide_i = 1'b1;
  logic        cs_n_i = 1'b1, ale_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1, bhe_n_i = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit cur_ds, cur_wide;
  logic [7:0] model [32];

  always #2.5 clk = ~clk;

  hostbus_regif uut (
    .clk(clk), .rst(rst), .mode_ds_i(mode_ds_i), .wide_i(wide_i),
    .cs_n_i(cs_n_i), .ale_i(ale_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .bhe_n_i(bhe_n_i), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input int ba, input bit bhe_n);
    logic [15:0] r;
    int w;
    r = '0;
    if (ba >= 32) return r;
    w = ba & ~1;
    if (cur_wide) begin
      if ((ba & 1) == 0) r[7:0] = model[w];
      if (!bhe_n) r[15:8] = model[w + 1];
    end else begin
      r[7:0] = model[ba];
    end
    return r;
  endfunction

  function automatic void model_write(input int ba, input bit bhe_n, input logic [15:0] d);
    int w;
    if (ba >= 32) return;
    w = ba & ~1;
    if (cur_wide) begin
      if ((ba & 1) == 0) model[w] = d[7:0];
      if (!bhe_n) model[w + 1] = d[15:8];
    end else begin
      model[ba] = d[7:0];
    end
  endfunction

  task automatic do_reset(input bit ds, input bit wide);
    @(negedge clk);
    rst = 1'b1; mode_ds_i = ds; wide_i = wide;
    cur_ds = ds; cur_wide = wide;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one host access; for reads, rdata holds data_o sampled mid-strobe
  task automatic access(input bit wr, input int ba, input bit mux, input bit bhe_n,
                        input logic [15:0] wd, output logic [15:0] rdata);
    @(negedge clk);
    bhe_n_i = bhe_n;
    if (mux) begin
      ale_i = 1'b1; addr_i = 8'(ba);
      repeat (4) @(negedge clk);
      ale_i = 1'b0;
      repeat (4) @(negedge clk);
      addr_i = wd[7:0] ^ 8'h5A;   // shared lines now carry data
    end else begin
      ale_i = 1'b1; addr_i = 8'(ba);
    end
    data_i = wd;
    if (cur_ds) begin
      wr_n_i = ~wr;
      @(negedge clk);
      cs_n_i = 1'b0; rd_n_i = 1'b0;
    end else begin
      cs_n_i = 1'b0;
      if (wr) wr_n_i = 1'b0; else rd_n_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    rdata = data_o;
    if (wr) check("R9 no drive during write", {15'b0, data_oe_o}, 16'h0);
    else    check("R4 oe during read", {15'b0, data_oe_o}, 16'h1);
    cs_n_i = 1'b1; rd_n_i = 1'b1;
    if (!cur_ds) wr_n_i = 1'b1;
    repeat (2) @(negedge clk);
    wr_n_i = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 oe released", {15'b0, data_oe_o}, 16'h0);
    if (wr) model_write(ba, bhe_n, wd);
  endtask

  task automatic wr_acc(input int ba, input bit mux, input bit bhe_n, input logic [15:0] wd);
    logic [15:0] dummy;
    access(1'b1, ba, mux, bhe_n, wd, dummy);
  endtask

  task automatic rd_chk(input string req, input int ba, input bit mux, input bit bhe_n);
    logic [15:0] got;
    access(1'b0, ba, mux, bhe_n, 16'h0, got);
    check(req, got, exp_read(ba, bhe_n));
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int ba;
      bit wr, mux, bhe;
      ba  = int'($urandom_range(0, 47));
      wr  = 1'($urandom_range(0, 1));
      mux = 1'($urandom_range(0, 1));
      bhe = 1'($urandom_range(0, 1));
      if (wr) wr_acc(ba, mux, bhe, 16'($urandom));
      else    rd_chk("R7/R8 random read", ba, mux, bhe);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    do_reset(1'b0, 1'b1);
    // R1: idle outputs after reset
    check("R1 reset oe", {15'b0, data_oe_o}, 16'h0);
    check("R1 reset data", data_o, 16'h0);

    // fill the bank with full-word writes (R3, R5, R7)
    for (int w = 0; w < 16; w++) wr_acc(w * 2, 1'b0, 1'b0, 16'(w * 16'h1111 + 16'h0203));
    rd_chk("R3 R4 R5 separate word read", 6, 1'b0, 1'b0);
    // R7: lane selects
    wr_acc(8, 1'b0, 1'b1, 16'hAAB1);            // low lane only
    rd_chk("R7 low lane write", 8, 1'b0, 1'b0);
    wr_acc(9, 1'b0, 1'b0, 16'hC3FF);            // high lane only
    rd_chk("R7 high lane write", 8, 1'b0, 1'b0);
    wr_acc(11, 1'b0, 1'b1, 16'hFFFF);           // no lane enabled
    rd_chk("R7 no lane write", 10, 1'b0, 1'b0);
    rd_chk("R7 high lane read", 11, 1'b0, 1'b0);
    // R2: multiplexed addressing with data on shared lines
    wr_acc(12, 1'b1, 1'b0, 16'h9E71);
    rd_chk("R2 multiplexed read", 12, 1'b1, 1'b0);
    rd_chk("R2 R3 cross read", 12, 1'b0, 1'b0);
    // R10: unmapped, no aliasing onto word 0
    wr_acc(32, 1'b0, 1'b0, 16'hDEAD);
    rd_chk("R10 unmapped read", 32, 1'b0, 1'b0);
    rd_chk("R10 no alias word0", 0, 1'b0, 1'b0);
    // R1: mode inputs changed after reset are ignored
    @(negedge clk); mode_ds_i = 1'b1; wide_i = 1'b0;
    wr_acc(14, 1'b0, 1'b0, 16'h1357);           // R11 one commit, checked by readback
    rd_chk("R1 R11 cfg frozen", 14, 1'b0, 1'b0);
    rand_phase(50);

    do_reset(1'b1, 1'b1);                        // R6 data-strobe, 16-bit
    wr_acc(4, 1'b1, 1'b0, 16'h4C2D);
    rd_chk("R6 data-strobe read", 4, 1'b1, 1'b0);
    rand_phase(50);

    do_reset(1'b0, 1'b0);                        // R8 separate strobes, 8-bit
    wr_acc(5, 1'b0, 1'b1, 16'h77E9);
    rd_chk("R8 odd byte", 5, 1'b0, 1'b1);
    rd_chk("R8 even byte", 4, 1'b0, 1'b1);
    rand_phase(50);

    do_reset(1'b1, 1'b0);                        // R6 R8 data-strobe, 8-bit
    wr_acc(33, 1'b1, 1'b1, 16'h0042);
    rd_chk("R10 narrow unmapped", 33, 1'b0, 1'b1);
    rd_chk("R10 narrow no alias", 1, 1'b0, 1'b1);
    rand_phase(50);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule